// File: doc/BRIEF.md
# Address Translation Cache with Scoped Invalidation

This block is a small fully associative cache of address translations. Each entry maps a virtual page number to a physical frame number. Each entry also holds an address-space tag, a global flag and a set of permission bits. A lookup is combinational: in the same cycle it reports a hit, a permission fault or a miss, together with the frame and permission bits of the matching entry. Entries arrive from an external page walker over a valid/ready refill port. The block drops an entry by itself in exactly one case: a lookup that hits an entry whose permissions do not cover the requested access. That entry is dropped, so a retry misses and refills with the new permissions.

Software keeps the cache consistent through an invalidate command port. The port has three scopes and a no-op code, and each command is acknowledged one cycle after it is issued. Writes to page-table memory never reach this block. A stale entry therefore stays until a command removes it. The refill port has no back-pressure: `fill_ready` is held high, and every cycle with `fill_valid` high writes one entry.

Top module: `xc_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses (`lk_hit` and `lk_fault` both low). `inv_ack` is low and `fill_ready` is high.
- R2: A lookup matches an entry only when all of these hold: the entry is valid, its virtual page equals `lk_vpn`, and it is either global or has a tag equal to `lk_asid`. On a match, `lk_pfn` and `lk_perm` carry that entry's fields in the same cycle.
- R3: Every cycle with `fill_valid` high writes one entry, and the entry is visible to lookups from the next cycle. The target is the lowest-numbered invalid entry.
- R4: When every entry is valid, a refill replaces the entry chosen by a round-robin pointer. The pointer starts at 0, advances by one after each such replacement and wraps after the last entry.
- R5: An invalidate with `inv_op`=2'b00 clears every entry, whatever its tag or global flag.
- R6: An invalidate with `inv_op`=2'b01 clears two kinds of entry. Non-global entries are cleared when both the virtual page equals `inv_vpn` and the tag equals `inv_asid`. Global entries are cleared when the virtual page equals `inv_vpn`, whatever the tag.
- R7: An invalidate with `inv_op`=2'b10 clears every non-global entry and keeps every global entry.
- R8: An invalidate with `inv_op`=2'b11 changes no entry but is still acknowledged.
- R9: `inv_ack` is high in exactly the cycle after each cycle with `inv_req` high. A lookup in the same cycle as an invalidate sees the contents from before the invalidate.
- R10: `lk_acc` names the access bits required (bit0 read, bit1 write, bit2 execute). If a matching entry lacks any of those bits, `lk_fault` rises, `lk_hit` stays low, and the entry is dropped at the clock edge.
- R11: If a refill and an invalidate arrive in the same cycle, the invalidate is applied to the contents that include the refilled entry. A refilled entry within the invalidate's scope is left invalid.
- R12: Lookups that do not fault and invalidates that match nothing leave every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_acc | input | PERM_W | Required access bits |
| lk_hit | output | 1 | Match with sufficient permission |
| lk_fault | output | 1 | Match with insufficient permission |
| lk_pfn | output | PFN_W | Frame of the matching entry |
| lk_perm | output | PERM_W | Permission bits of the matching entry |
| fill_valid | input | 1 | Refill entry offered |
| fill_ready | output | 1 | Refill accepted (always high) |
| fill_vpn | input | VPN_W | Refill virtual page |
| fill_asid | input | ASID_W | Refill address-space tag |
| fill_glob | input | 1 | Refill global flag |
| fill_pfn | input | PFN_W | Refill frame |
| fill_perm | input | PERM_W | Refill permission bits |
| inv_req | input | 1 | Invalidate command this cycle |
| inv_op | input | 2 | Invalidate scope code |
| inv_vpn | input | VPN_W | Page for address-scoped invalidate |
| inv_asid | input | ASID_W | Tag for address-scoped invalidate |
| inv_ack | output | 1 | Command completed |

## Verification
The bench targets five corner cases. First, an address-scoped invalidate that names the right page but the wrong tag: a design that ignores the tag would drop the entry, and a later lookup would miss. Second, a global entry under address-scoped and non-global invalidates: a design that treats the global flag wrongly either keeps a stale global entry or loses one it should keep. Third, a permission fault followed by a retry: a design that does not drop the entry would keep hitting stale permissions. Fourth, a refill in the same cycle as a matching invalidate: a design that orders these the wrong way leaves a live entry. Finally, round-robin replacement once the cache is full, and a lookup issued in the same cycle as an invalidate-all: a wrong pointer evicts the wrong page, and a wrong read order turns the pre-invalidate hit into a miss.

// File: rtl/xc_pkg.sv
`timescale 1ns/1ps
package xc_pkg;
  typedef enum logic [1:0] {
    INV_ALL       = 2'b00,
    INV_ADDR      = 2'b01,
    INV_NONGLOBAL = 2'b10,
    INV_NOP       = 2'b11
  } inv_op_e;
endpackage

// File: rtl/xc_victim.sv
`timescale 1ns/1ps
module xc_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_i,
  input  logic             fire_i,
  output logic [IDX_W-1:0] slot_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered free entry
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign slot_o = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fire_i && !any_free) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  // R3: a free slot is always preferred over the pointer
  assert_free_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i && !(&valid_i) |-> !valid_i[slot_o]);
endmodule

// File: rtl/xc_entry.sv
`timescale 1ns/1ps
module xc_entry
  import xc_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              drop,
  input  logic              inv_req,
  input  inv_op_e           inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              valid_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [PERM_W-1:0] perm_o,
  output logic              match_o
);
  logic              valid_q, glob_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PERM_W-1:0] perm_q;

  logic              n_valid, n_glob, kill;
  logic [VPN_W-1:0]  n_vpn;
  logic [ASID_W-1:0] n_asid;
  logic [PFN_W-1:0]  n_pfn;
  logic [PERM_W-1:0] n_perm;

  assign match_o = valid_q && (vpn_q == lk_vpn) && (glob_q || (asid_q == lk_asid));
  assign valid_o = valid_q;
  assign pfn_o   = pfn_q;
  assign perm_o  = perm_q;

  // stage 1: fault drop on old contents, refill overrides it
  always_comb begin
    n_valid = valid_q && !drop;
    n_vpn   = vpn_q;
    n_asid  = asid_q;
    n_glob  = glob_q;
    n_pfn   = pfn_q;
    n_perm  = perm_q;
    if (wr_en) begin
      n_valid = 1'b1;
      n_vpn   = wr_vpn;
      n_asid  = wr_asid;
      n_glob  = wr_glob;
      n_pfn   = wr_pfn;
      n_perm  = wr_perm;
    end
  end

  // stage 2: invalidate scope judged on the post-refill contents
  always_comb begin
    kill = 1'b0;
    if (inv_req) begin
      unique case (inv_op)
        INV_ALL:       kill = 1'b1;
        INV_ADDR:      kill = (n_vpn == inv_vpn) && (n_glob || (n_asid == inv_asid));
        INV_NONGLOBAL: kill = !n_glob;
        default:       kill = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      asid_q  <= '0;
      glob_q  <= 1'b0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else begin
      valid_q <= n_valid && !kill;
      vpn_q   <= n_vpn;
      asid_q  <= n_asid;
      glob_q  <= n_glob;
      pfn_q   <= n_pfn;
      perm_q  <= n_perm;
    end
  end

  assert_inv_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && inv_op == INV_ALL |=> !valid_q);

  assert_inv_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && inv_op == INV_ADDR && !wr_en && valid_q && vpn_q == inv_vpn &&
    !glob_q && asid_q == inv_asid |=> !valid_q);

  assert_ng_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && inv_op == INV_NONGLOBAL && !wr_en && !glob_q |=> !valid_q);

  assert_ng_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req && inv_op == INV_NONGLOBAL && !wr_en && !drop && glob_q && valid_q |=> valid_q);

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !wr_en |=> !valid_q);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !drop && !inv_req |=> $stable(valid_q) && $stable(vpn_q) &&
    $stable(pfn_q) && $stable(perm_q));
endmodule

// File: rtl/xc_tlb.sv
`timescale 1ns/1ps
module xc_tlb
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [PERM_W-1:0] lk_acc,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_glob,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_req,
  input  logic [1:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              inv_ack
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_vec, match_vec;
  logic [PFN_W-1:0]   pfn_a  [ENTRIES];
  logic [PERM_W-1:0]  perm_a [ENTRIES];
  logic [IDX_W-1:0]   slot;
  logic [PFN_W-1:0]   sel_pfn;
  logic [PERM_W-1:0]  sel_perm;
  logic               any_match, perm_ok, fill_fire;
  inv_op_e            op;

  assign op         = inv_op_e'(inv_op);
  assign fill_ready = 1'b1;
  assign fill_fire  = fill_valid && fill_ready;

  xc_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_vec), .fire_i(fill_fire), .slot_o(slot)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xc_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .PERM_W(PERM_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fill_fire && slot == IDX_W'(g)),
      .wr_vpn(fill_vpn), .wr_asid(fill_asid), .wr_glob(fill_glob),
      .wr_pfn(fill_pfn), .wr_perm(fill_perm),
      .drop(lk_fault && match_vec[g]),
      .inv_req(inv_req), .inv_op(op), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .valid_o(valid_vec[g]), .pfn_o(pfn_a[g]), .perm_o(perm_a[g]), .match_o(match_vec[g])
    );
  end

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        sel_pfn  = sel_pfn | pfn_a[i];
        sel_perm = sel_perm | perm_a[i];
      end
    end
  end

  assign any_match = |match_vec;
  assign perm_ok   = (sel_perm & lk_acc) == lk_acc;
  assign lk_hit    = lk_valid && any_match && perm_ok;
  assign lk_fault  = lk_valid && any_match && !perm_ok;
  assign lk_pfn    = sel_pfn;
  assign lk_perm   = sel_perm;

  always_ff @(posedge clk) begin
    if (!rst_n) inv_ack <= 1'b0;
    else        inv_ack <= inv_req;
  end

  always_comb begin
    if (rst_n) assert_hit_fault_excl_R10: assert (!(lk_hit && lk_fault));
  end

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && !inv_req |=> valid_vec[$past(slot)]);

  assert_fill_inv_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && inv_req && op == INV_ALL |=> $countones(valid_vec) == 0);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> valid_vec == '0 && !inv_ack);
endmodule

// File: tb/xc_tlb_test.sv
`timescale 1ns/1ps
module xc_tlb_test;
  localparam int K_FILL = 0, K_INV = 1, K_LOOK = 2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        glob;
    logic [19:0] pfn;
    logic [2:0]  perm;
    logic [1:0]  op;
    logic [2:0]  acc;
    logic        xhit;
    logic        xfault;
    logic [19:0] xpfn;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t vf(logic [19:0] vpn, logic [7:0] asid, logic glob,
                              logic [19:0] pfn, logic [2:0] perm, logic [3:0] req);
    vf = '0; vf.kind = 2'(K_FILL); vf.vpn = vpn; vf.asid = asid; vf.glob = glob;
    vf.pfn = pfn; vf.perm = perm; vf.req = req;
  endfunction
  function automatic vec_t vi(logic [1:0] op, logic [19:0] vpn, logic [7:0] asid, logic [3:0] req);
    vi = '0; vi.kind = 2'(K_INV); vi.op = op; vi.vpn = vpn; vi.asid = asid; vi.req = req;
  endfunction
  function automatic vec_t vl(logic [19:0] vpn, logic [7:0] asid, logic [2:0] acc,
                              logic xh, logic xf, logic [19:0] xpfn, logic [3:0] req);
    vl = '0; vl.kind = 2'(K_LOOK); vl.vpn = vpn; vl.asid = asid; vl.acc = acc;
    vl.xhit = xh; vl.xfault = xf; vl.xpfn = xpfn; vl.req = req;
  endfunction

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    vf(20'h10, 8'd1, 1'b0, 20'hA10, 3'b011, 4'd3),  // R3 slot0
    vf(20'h20, 8'd2, 1'b1, 20'hA20, 3'b111, 4'd3),  // R3 slot1 global
    vf(20'h30, 8'd1, 1'b0, 20'hA30, 3'b001, 4'd3),  // R3 slot2
    vl(20'h10, 8'd1, 3'b001, 1, 0, 20'hA10, 4'd2),  // R2 hit
    vl(20'h10, 8'd2, 3'b001, 0, 0, 20'h0, 4'd2),    // R2 tag mismatch
    vl(20'h20, 8'd7, 3'b001, 1, 0, 20'hA20, 4'd2),  // R2 global any tag
    vl(20'h40, 8'd1, 3'b001, 0, 0, 20'h0, 4'd2),    // R2 page miss
    vl(20'h10, 8'd1, 3'b010, 1, 0, 20'hA10, 4'd12), // R12 repeated lookup
    vi(2'b01, 20'h10, 8'd2, 4'd6),                  // R6 wrong tag
    vl(20'h10, 8'd1, 3'b001, 1, 0, 20'hA10, 4'd6),  // R6 survives
    vi(2'b01, 20'h10, 8'd1, 4'd6),                  // R6 exact
    vl(20'h10, 8'd1, 3'b001, 0, 0, 20'h0, 4'd6),    // R6 gone
    vi(2'b01, 20'h20, 8'd9, 4'd6),                  // R6 global by page
    vl(20'h20, 8'd3, 3'b001, 0, 0, 20'h0, 4'd6),    // R6 gone
    vl(20'h30, 8'd1, 3'b010, 0, 1, 20'hA30, 4'd10), // R10 fault
    vl(20'h30, 8'd1, 3'b001, 0, 0, 20'h0, 4'd10),   // R10 dropped
    vf(20'h30, 8'd1, 1'b0, 20'hA31, 3'b011, 4'd10), // R10 refill
    vl(20'h30, 8'd1, 3'b010, 1, 0, 20'hA31, 4'd10), // R10 retry hits
    vi(2'b11, 20'h30, 8'd1, 4'd8),                  // R8 no-op
    vl(20'h30, 8'd1, 3'b001, 1, 0, 20'hA31, 4'd8),  // R8 still there
    vf(20'h50, 8'd4, 1'b1, 20'hA50, 3'b101, 4'd7),  // R7 global
    vf(20'h60, 8'd4, 1'b0, 20'hA60, 3'b111, 4'd7),  // R7 local
    vi(2'b10, 20'h0, 8'd0, 4'd7),                   // R7 non-global
    vl(20'h50, 8'd5, 3'b001, 1, 0, 20'hA50, 4'd7),  // R7 kept
    vl(20'h60, 8'd4, 3'b001, 0, 0, 20'h0, 4'd7),    // R7 cleared
    vl(20'h30, 8'd1, 3'b001, 0, 0, 20'h0, 4'd7),    // R7 cleared
    vi(2'b00, 20'h0, 8'd0, 4'd5),                   // R5 all
    vl(20'h50, 8'd5, 3'b001, 0, 0, 20'h0, 4'd5)     // R5 global gone
  };

  logic clk = 0, rst_n = 0;
  logic lk_valid, fill_valid, fill_glob, inv_req;
  logic [19:0] lk_vpn, fill_vpn, fill_pfn, inv_vpn;
  logic [7:0]  lk_asid, fill_asid, inv_asid;
  logic [2:0]  lk_acc, fill_perm;
  logic [1:0]  inv_op;
  logic lk_hit, lk_fault, fill_ready, inv_ack;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_perm;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xc_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_glob(fill_glob), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .inv_req(inv_req), .inv_op(inv_op), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
    .inv_ack(inv_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vpn = 0; lk_asid = 0; lk_acc = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_glob = 0; fill_pfn = 0; fill_perm = 0;
    inv_req = 0; inv_op = 0; inv_vpn = 0; inv_asid = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [7:0] asid, input logic exp_hit,
                      input logic [19:0] exp_pfn, input string tag);
    @(negedge clk); idle();
    lk_valid = 1; lk_vpn = vpn; lk_asid = asid; lk_acc = 3'b001;
    #2;
    chk(lk_hit === exp_hit, tag, 32'(lk_hit), 32'(exp_hit));
    if (exp_hit) chk(lk_pfn === exp_pfn, tag, 32'(lk_pfn), 32'(exp_pfn));
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic glob);
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_glob = glob;
    fill_pfn = vpn ^ 20'hF0000; fill_perm = 3'b111;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    lk_valid = 1; lk_vpn = 0; lk_asid = 0; lk_acc = 0;
    #2;
    chk(lk_hit === 0 && lk_fault === 0, "R1 lookup after reset", 32'({lk_hit, lk_fault}), 0);
    chk(inv_ack === 0, "R1 ack after reset", 32'(inv_ack), 0);
    chk(fill_ready === 1, "R1 fill_ready", 32'(fill_ready), 1);

    // vector table
    foreach (TBL[i]) begin
      @(negedge clk); idle();
      case (int'(TBL[i].kind))
        K_FILL: begin
          fill_valid = 1; fill_vpn = TBL[i].vpn; fill_asid = TBL[i].asid;
          fill_glob = TBL[i].glob; fill_pfn = TBL[i].pfn; fill_perm = TBL[i].perm;
        end
        K_INV: begin
          inv_req = 1; inv_op = TBL[i].op; inv_vpn = TBL[i].vpn; inv_asid = TBL[i].asid;
        end
        default: begin
          lk_valid = 1; lk_vpn = TBL[i].vpn; lk_asid = TBL[i].asid; lk_acc = TBL[i].acc;
          #2;
          chk(lk_hit === TBL[i].xhit, $sformatf("R%0d hit vec%0d", TBL[i].req, i),
              32'(lk_hit), 32'(TBL[i].xhit));
          chk(lk_fault === TBL[i].xfault, $sformatf("R%0d fault vec%0d", TBL[i].req, i),
              32'(lk_fault), 32'(TBL[i].xfault));
          if (TBL[i].xhit || TBL[i].xfault)
            chk(lk_pfn === TBL[i].xpfn, $sformatf("R%0d pfn vec%0d", TBL[i].req, i),
                32'(lk_pfn), 32'(TBL[i].xpfn));
        end
      endcase
    end

    // R4 round-robin after full
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 8'd1, 1'b0);
    fill(20'h108, 8'd1, 1'b0);
    fill(20'h109, 8'd1, 1'b0);
    look(20'h100, 8'd1, 0, 0, "R4 slot0 evicted");
    look(20'h101, 8'd1, 0, 0, "R4 slot1 evicted");
    look(20'h102, 8'd1, 1, 20'h102 ^ 20'hF0000, "R4 slot2 kept");
    look(20'h108, 8'd1, 1, 20'h108 ^ 20'hF0000, "R4 new entry");
    look(20'h109, 8'd1, 1, 20'h109 ^ 20'hF0000, "R4 new entry 2");

    // R9 ack timing and pre-invalidate lookup
    @(negedge clk); idle();
    inv_req = 1; inv_op = 2'b00;
    lk_valid = 1; lk_vpn = 20'h102; lk_asid = 8'd1; lk_acc = 3'b001;
    #2;
    chk(lk_hit === 1, "R9 same-cycle lookup sees old contents", 32'(lk_hit), 1);
    @(posedge clk); #2;
    chk(inv_ack === 1, "R9 ack next cycle", 32'(inv_ack), 1);
    look(20'h102, 8'd1, 0, 0, "R9 cleared after invalidate");
    @(posedge clk); #2;
    chk(inv_ack === 0, "R9 ack single cycle", 32'(inv_ack), 0);

    // R11 refill + invalidate in the same cycle
    fill(20'h200, 8'd3, 1'b0);
    inv_req = 1; inv_op = 2'b01; inv_vpn = 20'h200; inv_asid = 8'd3;
    look(20'h200, 8'd3, 0, 0, "R11 addr invalidate wins");
    fill(20'h201, 8'd3, 1'b1);
    inv_req = 1; inv_op = 2'b10;
    look(20'h201, 8'd6, 1, 20'h201 ^ 20'hF0000, "R11 global survives non-global");
    fill(20'h202, 8'd3, 1'b0);
    inv_req = 1; inv_op = 2'b10;
    look(20'h202, 8'd3, 0, 0, "R11 local refill killed");

    @(negedge clk); idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule